// File: doc/BRIEF.md
# Soft Mute Attenuation Ramp

This block fades a stereo stream of 24-bit two's-complement samples in and out. It advances by one step per output frame, and each frame is marked by a one-cycle strobe. A mute request lowers a shared gain one step per frame, from unity to silence. Withdrawing the request raises the gain again at the same rate. A change of request partway through a fade turns the fade around from wherever it stands, so the level never jumps.

The gain is an integer position between 0 and 1024. Both channels are multiplied by position/1024 and rounded back to 24 bits. A semi-automatic start-up mode is chosen while reset is held. In that mode the output stays silent for a fixed number of frames after reset is released, and the mute request is ignored during that time. The gain then rises. The active-low reset also acts as the power-down input: while it is low, the outputs are zero.

Top module: `soft_mute_ramp`

## Requirements
- R1: For each frame strobe, each output channel equals floor((sample * g + 512) / 1024), computed as signed arithmetic. Here g is the gain position (0 to 1024) held before that frame's step, and both channels use the same g. At g = 1024 the output equals the input.
- R2: While the mute request is high at a strobe and g is above 0, g falls by exactly 1 at that strobe. From unity, silence is therefore reached after 1024 frames.
- R3: While the mute request is low at a strobe and g is below 1024, g rises by exactly 1 at that strobe. From silence, unity is therefore reached after 1024 frames.
- R4: A change of mute request during a fade reverses the direction from the present g, without restarting at an end point.
- R5: At g = 0 both output samples are exactly zero, whatever the input.
- R6: While rst_n is low, both outputs are zero and out_stb is low. After release in manual mode (semi_auto low during reset), g starts at 1024.
- R7: If semi_auto is high while reset is held, then for the first 4410 strobes after release the outputs are zero and g stays at 0 whatever the mute request does. After that, g steps one per frame toward the requested end.
- R8: The outputs change only at a frame strobe. out_stb is high in exactly the cycle after each strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset and power-down |
| frame_stb | input | 1 | One-cycle pulse per output frame |
| mute_req | input | 1 | 1 requests silence, 0 requests unity gain |
| semi_auto | input | 1 | Start-up mode, sampled while reset is low |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_left | output | 24 | Left scaled sample |
| out_right | output | 24 | Right scaled sample |
| out_stb | output | 1 | High in the cycle after a strobe, when new outputs are present |

## Verification
Each scaled sample is registered at the clock edge where frame_stb is high. The sample uses the gain from before that edge's step, so the result is present one cycle after the strobe and out_stb rises in the same cycle. The bench raises the strobe at a falling edge and reads the outputs at the next falling edge. It advances its own gain model only after comparing that frame. The hold and the fades are counted in strobes, not cycles: the first frame that may be non-zero after a semi-automatic start is the 4412th strobe, and a fade from unity first gives zero on the 1025th frame.

// File: rtl/smr_pkg.sv
// Shared types for the soft mute ramp.
package smr_pkg;
    // Number of audio channels sharing one gain
    localparam int SMR_CHANNELS = 2;

    // Direction of the gain step applied at the next frame strobe
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_DOWN = 2'd1,
        DIR_UP   = 2'd2
    } ramp_dir_e;
endpackage

// File: rtl/smr_gain_ctrl.sv
// Gain position controller.
// Keeps the ramp position (0 = silence, RAMP_LEN = unity) and the
// start-up hold. Assumes frame_stb is a single-cycle pulse. The position
// reported at a strobe is the one used for that frame; the step is taken
// at the same edge.
module smr_gain_ctrl
    import smr_pkg::*;
#(
    parameter int RAMP_LEN    = 1024,
    parameter int HOLD_FRAMES = 4410,
    localparam int LVL_W      = $clog2(RAMP_LEN + 1),
    localparam int HCNT_W     = $clog2(HOLD_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             mute_req,
    input  logic             semi_auto,
    output logic [LVL_W-1:0] gain,
    output logic             hold
);
    localparam logic [LVL_W-1:0]  LVL_MAX  = LVL_W'(RAMP_LEN);
    localparam logic [HCNT_W-1:0] HOLD_END = HCNT_W'(HOLD_FRAMES - 1);

    logic [HCNT_W-1:0] hold_cnt;
    ramp_dir_e         dir;

    // Choose the step direction from the request and the present position
    always_comb begin
        if (hold)
            dir = DIR_HOLD;
        else if (mute_req && gain != '0)
            dir = DIR_DOWN;
        else if (!mute_req && gain != LVL_MAX)
            dir = DIR_UP;
        else
            dir = DIR_HOLD;
    end

    // Advance the hold counter and the gain position once per frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain     <= semi_auto ? '0 : LVL_MAX;
            hold     <= semi_auto;
            hold_cnt <= '0;
        end else if (frame_stb) begin
            if (hold) begin
                hold_cnt <= hold_cnt + 1'b1;
                if (hold_cnt == HOLD_END)
                    hold <= 1'b0;
            end
            unique case (dir)
                DIR_DOWN: gain <= gain - 1'b1;
                DIR_UP:   gain <= gain + 1'b1;
                default:  gain <= gain;
            endcase
        end
    end

    // Position never leaves its range
    assert_gain_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        gain <= LVL_MAX);

    // At most one step per frame, so a reversal continues from the present level
    assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (gain == $past(gain) || gain == $past(gain) + 1'b1
                       || gain + 1'b1 == $past(gain)));

    // Mute high at a strobe never raises the gain
    assert_mute_no_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && mute_req) |=> gain <= $past(gain));

    // Mute low at a strobe never lowers the gain
    assert_unmute_no_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !mute_req) |=> gain >= $past(gain));

    // Start-up hold keeps the gain at silence
    assert_hold_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> gain == '0);

    // No strobe, no change
    assert_gain_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(gain));
endmodule

// File: rtl/smr_scaler.sv
// One channel gain multiplier.
// Registers round(din * gain / RAMP_LEN), rounding half up, at each frame
// strobe, or zero when force_zero is set. Assumes RAMP_LEN is a power of
// two and gain <= RAMP_LEN, so the result always fits DATA_W bits.
module smr_scaler #(
    parameter int DATA_W   = 24,
    parameter int RAMP_LEN = 1024,
    localparam int LVL_W   = $clog2(RAMP_LEN + 1),
    localparam int SHIFT   = $clog2(RAMP_LEN),
    localparam int PROD_W  = DATA_W + LVL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              force_zero,
    input  logic [LVL_W-1:0]  gain,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(RAMP_LEN / 2);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rounded;

    // Signed multiply by the gain, then add half an LSB of the result
    always_comb begin
        prod    = $signed(din) * $signed({1'b0, gain});
        rounded = prod + HALF;
    end

    // Register the scaled sample once per frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (frame_stb)
            dout <= force_zero ? '0 : DATA_W'(rounded >>> SHIFT);
    end

    // Silence gives an exact zero
    assert_zero_at_mute_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && (gain == '0 || force_zero)) |=> dout == '0);

    // Unity passes the sample through
    assert_unity_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !force_zero && gain == LVL_W'(RAMP_LEN)) |=> dout == $past(din));
endmodule

// File: rtl/soft_mute_ramp.sv
// Stereo soft mute ramp, top level.
// One gain controller drives one scaler per channel, so every channel uses
// the same gain in each frame. rst_n doubles as power-down: the outputs are
// zero while it is low. Assumes frame_stb is a single-cycle pulse.
module soft_mute_ramp
    import smr_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int RAMP_LEN    = 1024,
    parameter int HOLD_FRAMES = 4410,
    localparam int LVL_W      = $clog2(RAMP_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              mute_req,
    input  logic              semi_auto,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              out_stb
);
    logic [LVL_W-1:0]  gain;
    logic              hold;
    logic [DATA_W-1:0] ch_in  [SMR_CHANNELS];
    logic [DATA_W-1:0] ch_out [SMR_CHANNELS];

    // Map the stereo ports onto the channel arrays
    always_comb begin
        ch_in[0]  = in_left;
        ch_in[1]  = in_right;
        out_left  = ch_out[0];
        out_right = ch_out[1];
    end

    smr_gain_ctrl #(
        .RAMP_LEN    (RAMP_LEN),
        .HOLD_FRAMES (HOLD_FRAMES)
    ) i_gain_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .mute_req  (mute_req),
        .semi_auto (semi_auto),
        .gain      (gain),
        .hold      (hold)
    );

    for (genvar ch = 0; ch < SMR_CHANNELS; ch++) begin : g_chan
        smr_scaler #(
            .DATA_W   (DATA_W),
            .RAMP_LEN (RAMP_LEN)
        ) i_scaler (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_stb  (frame_stb),
            .force_zero (hold),
            .gain       (gain),
            .din        (ch_in[ch]),
            .dout       (ch_out[ch])
        );
    end

    // Flag the cycle in which a new frame result is present
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_stb <= 1'b0;
        else
            out_stb <= frame_stb;
    end

    // Power-down forces silence on both channels
    assert_pd_silent_R6: assert property (@(posedge clk)
        !rst_n |=> (out_left == '0 && out_right == '0 && !out_stb));

    // Outputs move only after a strobe
    assert_out_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(out_left) && $stable(out_right) && !out_stb));
endmodule

// File: tb/test_soft_mute_ramp.sv
module test_soft_mute_ramp;
    localparam int W = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_stb = 1'b0;
    logic          mute_req = 1'b0;
    logic          semi_auto = 1'b0;
    logic [W-1:0]  in_left = '0;
    logic [W-1:0]  in_right = '0;
    logic [W-1:0]  out_left;
    logic [W-1:0]  out_right;
    logic          out_stb;

    int checks = 0;
    int errors = 0;
    int g_model = 1024;

    always #10 clk = ~clk;

    soft_mute_ramp i_soft_mute_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .mute_req  (mute_req),
        .semi_auto (semi_auto),
        .in_left   (in_left),
        .in_right  (in_right),
        .out_left  (out_left),
        .out_right (out_right),
        .out_stb   (out_stb)
    );

    typedef struct packed {
        logic        mute;
        logic [15:0] frames;
        logic [23:0] left;
        logic [23:0] right;
    } vec_t;

    // Fade stimulus: unity, full fade down, partial up, reversal, full up
    localparam vec_t VEC [5] = '{
        '{1'b0, 16'd4,    24'h123456, 24'hF00000},
        '{1'b1, 16'd1030, 24'h7FFFFF, 24'h800000},
        '{1'b0, 16'd300,  24'h400000, 24'hBFFFFF},
        '{1'b1, 16'd100,  24'h2AAAAB, 24'hD55555},
        '{1'b0, 16'd1100, 24'h765432, 24'h89ABCD}
    };

    task automatic chk(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic longint scale(input logic [W-1:0] s, input int g);
        longint p;
        p = longint'($signed(s)) * g;
        return (p + 512) >>> 10;
    endfunction

    // One frame: strobe at a falling edge, read the result one falling edge later
    task automatic frame(input logic m, input logic [W-1:0] l, input logic [W-1:0] r);
        @(negedge clk);
        frame_stb = 1'b1;
        mute_req  = m;
        in_left   = l;
        in_right  = r;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    // Frame checked against the bench model, then the model steps
    task automatic model_frame(input string tag, input logic m,
                               input logic [W-1:0] l, input logic [W-1:0] r);
        frame(m, l, r);
        chk(tag, longint'($signed(out_left)),  scale(l, g_model));
        chk(tag, longint'($signed(out_right)), scale(r, g_model));
        if (m && g_model > 0) g_model--;
        else if (!m && g_model < 1024) g_model++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R6: power-down state with strobes and data applied
        semi_auto = 1'b0;
        repeat (2) frame(1'b0, 24'h7FFFFF, 24'h7FFFFF);
        chk("R6 left in power-down",  out_left, 0);
        chk("R6 right in power-down", out_right, 0);
        chk("R6 out_stb in power-down", out_stb, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R1 unity, R2 fade down, R5 silence, R3 fade up, R4 reversal
        g_model = 1024;
        foreach (VEC[i]) begin
            for (int f = 0; f < int'(VEC[i].frames); f++) begin
                model_frame(VEC[i].mute ? "R2 R4 R5 fade" : "R1 R3 R4 fade",
                            VEC[i].mute, VEC[i].left, VEC[i].right);
                if (i == 1 && f == 1023) begin
                    chk("R2 last step before silence", out_left, 24'd8192);
                end
                if (i == 1 && f == 1024) begin
                    chk("R5 silence left",  out_left, 0);
                    chk("R5 silence right", out_right, 0);
                end
            end
        end
        chk("R3 model back at unity", g_model, 1024);

        // R8: out_stb one cycle after the strobe, outputs frozen without a strobe
        frame(1'b0, 24'h000123, 24'h000456);
        chk("R8 out_stb after strobe", out_stb, 1);
        chk("R1 unity left", out_left, 24'h000123);
        in_left = 24'h7FFFFF;
        in_right = 24'h800000;
        mute_req = 1'b1;
        @(negedge clk);
        chk("R8 out_stb without strobe", out_stb, 0);
        repeat (3) @(negedge clk);
        chk("R8 left held", out_left, 24'h000123);
        chk("R8 right held", out_right, 24'h000456);

        // R6: reset in manual mode with mute high starts from unity
        rst_n = 1'b0;
        @(negedge clk);
        chk("R6 outputs cleared", out_left, 0);
        rst_n = 1'b1;
        g_model = 1024;
        model_frame("R6 manual start at unity", 1'b1, 24'h654321, 24'h9ABCDF);
        chk("R6 first frame unity", out_left, 24'h654321);
        model_frame("R6 R2 second frame", 1'b1, 24'h654321, 24'h9ABCDF);

        // R7: semi-automatic start-up hold, mute request ignored
        @(negedge clk);
        rst_n = 1'b0;
        semi_auto = 1'b1;
        frame(1'b0, 24'h7FFFFF, 24'h7FFFFF);
        chk("R6 semi reset silent", out_right, 0);
        rst_n = 1'b1;
        semi_auto = 1'b0;
        for (int f = 0; f < 4410; f++) begin
            frame((f % 3) == 0, 24'h7FFFFF, 24'h800000);
            chk("R7 hold left", out_left, 0);
            chk("R7 hold right", out_right, 0);
        end
        g_model = 0;
        model_frame("R7 first frame after hold", 1'b0, 24'h7FFFFF, 24'h800000);
        model_frame("R7 ramp begins", 1'b0, 24'h7FFFFF, 24'h800000);
        chk("R7 gain one after hold", out_left, 24'd8192);
        for (int f = 0; f < 20; f++)
            model_frame("R7 R3 rising", 1'b0, 24'h7FFFFF, 24'h800000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule